// File: doc/BRIEF.md
# Vector Element Rotate/Shift Unit

This unit takes a 128-bit vector and rotates or shifts each of its elements independently. The elements are either four 32-bit words or eight 16-bit halfwords. The amount for each element comes from one of two places: the matching element of a second 128-bit vector, or a 7-bit signed immediate that applies to every element. Right shifts follow the negated-count convention. The caller writes the amount as a negative number, and the unit shifts by the two's-complement negation of the count, reduced modulo twice the element width. Any amount that reaches the element width empties the element, or fills it with copies of its sign bit.

The operation is selected by a 3-bit opcode and a 1-bit element-size select. One register stage sits between the inputs and the result. A result appears one clock after `in_valid` is sampled high, flagged by `out_valid`. Element 0 is the most significant element of the vector.

Top module: `vrs_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `result` is all zeros. Each cycle with `in_valid`=1 produces `out_valid`=1 and the new result on the next clock. A cycle with `in_valid`=0 gives `out_valid`=0 on the next clock and leaves `result` unchanged.
- R2: Rotate left (opcode 0) rotates each element by its count modulo the element width: bits [4:0] of the count for words, bits [3:0] for halfwords. Bits shifted out at the top re-enter at the bottom.
- R3: Word logical right shift (opcode 1, size 0) shifts by (0 − count) mod 64 and fills with zeros. The element becomes 0 when that amount is 32 or more.
- R4: Word arithmetic right shift (opcode 2, size 0) shifts by (0 − count) mod 64 and fills with the sign bit. The element becomes all copies of its sign bit when that amount is 32 or more.
- R5: Word left shift (opcode 3, size 0) shifts by count mod 64 and fills with zeros. The element becomes 0 when that amount is 32 or more.
- R6: Halfword logical and arithmetic right shifts (opcodes 1 and 2, size 1) shift by (0 − count) mod 32. An amount of 16 or more gives 0 for the logical shift and a full sign fill for the arithmetic shift.
- R7: Halfword left shift (opcode 3, size 1) shifts by count mod 32 and gives 0 when that amount is 16 or more.
- R8: When `use_imm`=1, the 7-bit two's-complement `imm` is sign-extended and used as the count of every element, with the same reductions as above. The effective masks are 0x1F/0x3F/0x3F for word rotate/right/left and 0xF/0x1F/0x1F for halfword rotate/right/left.
- R9: When `use_imm`=0, element i of `a` takes its count from element i of `b`. Element 0 occupies the most significant bits: word i is bits [127−32i -: 32] and halfword i is bits [127−16i -: 16].
- R10: Opcodes 4 to 7 copy `a` to `result` unchanged. `size` 0 selects words and 1 selects halfwords.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 3 | 0 rotate, 1 logical right, 2 arithmetic right, 3 left, 4-7 pass-through |
| size | input | 1 | 0 = four words, 1 = eight halfwords |
| use_imm | input | 1 | 1 = count from `imm`, 0 = count from `b` |
| a | input | 128 | Data vector |
| b | input | 128 | Per-element count vector |
| imm | input | 7 | Signed immediate count |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result vector |

## Verification
The bench drives every operation, in both element sizes and both count sources, with raw counts of 0, width−1, width, width+1 and 63, and with their negations. At these counts a design that reduced a count with the wrong modulus would return the data unshifted where it should return zero or a sign fill. A design that negated the count on the wrong path would shift in the wrong direction. In the register form the counts differ from element to element, and the halfword counts carry garbage in their upper byte. A swapped element order would therefore use a neighbour's count, and a rotate that read the whole halfword would pick up a wrong amount. Signed data with the top bit set shows whether the arithmetic shifts fill with the sign bit or with zeros.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    localparam int VEC_W  = 128;
    localparam int IMM_W  = 7;
    localparam int OP_W   = 3;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [OP_W-1:0] {
        VRS_ROTL = 3'd0,
        VRS_SRL  = 3'd1,
        VRS_SRA  = 3'd2,
        VRS_SLL  = 3'd3
    } vrs_op_e;

    typedef enum logic {
        VRS_WORD = 1'b0,
        VRS_HALF = 1'b1
    } vrs_size_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic             use_imm;
        logic [IMM_W-1:0] imm;
    } vrs_ctrl_t;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } vrs_out_t;

    function automatic logic vrs_is_pass(input logic [OP_W-1:0] op);
        return op[OP_W-1];
    endfunction

endpackage

// File: rtl/vrs_lane.sv
module vrs_lane
    import vrs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    din,
    input  logic [W-1:0]    cnt,
    output logic [W-1:0]    dout
);
    localparam int LG = $clog2(W);
    localparam int CW = LG + 1;

    logic [CW-1:0]  raw_amt;
    logic [CW-1:0]  neg_amt;
    logic [2*W-1:0] rot_dbl;
    logic           unused_cnt_hi;

    assign raw_amt       = cnt[CW-1:0];
    assign neg_amt       = -raw_amt;
    assign rot_dbl       = {din, din} << raw_amt[LG-1:0];
    assign unused_cnt_hi = ^cnt[W-1:CW];

    always_comb begin
        case (op)
            VRS_ROTL: dout = rot_dbl[2*W-1:W];
            VRS_SRL:  dout = neg_amt[LG] ? '0 : (din >> neg_amt[LG-1:0]);
            VRS_SRA:  dout = neg_amt[LG] ? {W{din[W-1]}}
                                         : W'($signed(din) >>> neg_amt[LG-1:0]);
            VRS_SLL:  dout = raw_amt[LG] ? '0 : (din << raw_amt[LG-1:0]);
            default:  dout = din;
        endcase
    end

endmodule

// File: rtl/vrs_lane_array.sv
module vrs_lane_array
    import vrs_pkg::*;
#(
    parameter int W    = 32,
    parameter int VW   = VEC_W
) (
    input  vrs_ctrl_t     ctrl,
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    localparam int N = VW / W;

    logic [W-1:0] imm_ext;
    assign imm_ext = {{(W-IMM_W){ctrl.imm[IMM_W-1]}}, ctrl.imm};

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W-1:0] lane_a;
        logic [W-1:0] lane_c;
        logic [W-1:0] lane_y;

        assign lane_a = a[VW-1-i*W -: W];
        assign lane_c = ctrl.use_imm ? imm_ext : b[VW-1-i*W -: W];

        vrs_lane #(.W(W)) u_lane (
            .op   (ctrl.op),
            .din  (lane_a),
            .cnt  (lane_c),
            .dout (lane_y)
        );

        assign y[VW-1-i*W -: W] = lane_y;
    end

endmodule

// File: rtl/vrs_unit.sv
module vrs_unit
    import vrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic             size,
    input  logic             use_imm,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    vrs_ctrl_t        ctrl;
    logic [VEC_W-1:0] word_y;
    logic [VEC_W-1:0] half_y;
    vrs_out_t         nxt;
    vrs_out_t         q;

    assign ctrl = '{op: op, use_imm: use_imm, imm: imm};

    vrs_lane_array #(.W(WORD_W), .VW(VEC_W)) u_words (
        .ctrl (ctrl),
        .a    (a),
        .b    (b),
        .y    (word_y)
    );

    vrs_lane_array #(.W(HALF_W), .VW(VEC_W)) u_halves (
        .ctrl (ctrl),
        .a    (a),
        .b    (b),
        .y    (half_y)
    );

    always_comb begin
        nxt.vld  = in_valid;
        nxt.data = q.data;
        if (in_valid) begin
            if (vrs_is_pass(op))
                nxt.data = a;
            else
                nxt.data = (size == VRS_HALF) ? half_y : word_y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign out_valid = q.vld;
    assign result    = q.data;

    logic [4:0] chk_hneg;
    assign chk_hneg = 5'd0 - imm[4:0];

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                                     // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));                              // R1
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2]) |=> (result == $past(a)));                               // R10
    AST_WROT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && size == 1'b0 && use_imm && imm[4:0] == 5'd0)
        |=> (result == $past(a)));                                                   // R2
    AST_WSHL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3 && size == 1'b0 && use_imm && imm[5])
        |=> (result == '0));                                                         // R5
    AST_HSRL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd1 && size == 1'b1 && use_imm && chk_hneg[4])
        |=> (result == '0));                                                         // R6

endmodule

// File: tb/vrs_unit_tb_top.sv
module vrs_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op;
    logic         size;
    logic         use_imm;
    logic [127:0] a;
    logic [127:0] b;
    logic [6:0]   imm;
    logic         out_valid;
    logic [127:0] result;

    always #10 clk = ~clk;

    vrs_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
        .use_imm(use_imm), .a(a), .b(b), .imm(imm),
        .out_valid(out_valid), .result(result)
    );

    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    logic [127:0] last_exp;

    function automatic logic [127:0] ref_model(input logic [2:0] f_op, input logic f_sz,
            input logic f_im, input logic [127:0] f_a, input logic [127:0] f_b,
            input logic [6:0] f_imm);
        logic [127:0] y;
        y = f_a;
        if (f_op >= 3'd4) return f_a;
        if (!f_sz) begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] ae, ce, ye;
                longint      sv;
                int          n;
                ae = f_a[127-32*i -: 32];
                ce = f_im ? {{25{f_imm[6]}}, f_imm} : f_b[127-32*i -: 32];
                case (f_op)
                    3'd0: begin
                        n  = int'(ce) & 31;
                        ye = (n == 0) ? ae : ((ae << n) | (ae >> (32 - n)));
                    end
                    3'd1: begin
                        n  = (0 - int'(ce)) & 63;
                        sv = longint'({32'd0, ae}) >> n;
                        ye = sv[31:0];
                    end
                    3'd2: begin
                        n  = (0 - int'(ce)) & 63;
                        sv = longint'($signed(ae));
                        sv = sv >>> n;
                        ye = sv[31:0];
                    end
                    default: begin
                        n  = int'(ce) & 63;
                        sv = longint'({32'd0, ae}) << n;
                        ye = sv[31:0];
                    end
                endcase
                y[127-32*i -: 32] = ye;
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] ae, ce, ye;
                int          sv;
                int          n;
                ae = f_a[127-16*i -: 16];
                ce = f_im ? {{9{f_imm[6]}}, f_imm} : f_b[127-16*i -: 16];
                case (f_op)
                    3'd0: begin
                        n  = int'(ce[7:0]) % 16;
                        ye = (n == 0) ? ae : ((ae << n) | (ae >> (16 - n)));
                    end
                    3'd1: begin
                        n  = (0 - int'(ce)) & 31;
                        sv = int'({16'd0, ae}) >> n;
                        ye = sv[15:0];
                    end
                    3'd2: begin
                        n  = (0 - int'(ce)) & 31;
                        sv = int'($signed(ae));
                        sv = sv >>> n;
                        ye = sv[15:0];
                    end
                    default: begin
                        n  = int'(ce) & 31;
                        sv = int'({16'd0, ae}) << n;
                        ye = sv[15:0];
                    end
                endcase
                y[127-16*i -: 16] = ye;
            end
        end
        return y;
    endfunction

    function automatic string tag_of(input logic [2:0] f_op, input logic f_sz, input logic f_im);
        string t;
        if (f_op >= 3'd4)      t = "R10";
        else if (f_op == 3'd0) t = "R2";
        else if (!f_sz)        t = (f_op == 3'd1) ? "R3" : (f_op == 3'd2) ? "R4" : "R5";
        else                   t = (f_op == 3'd3) ? "R7" : "R6";
        return f_im ? {t, " R8"} : {t, " R9"};
    endfunction

    function automatic int cnt_pick(input int j, input int w);
        case (j % 11)
            0:  return 0;
            1:  return w - 1;
            2:  return w;
            3:  return w + 1;
            4:  return 63;
            5:  return -1;
            6:  return -(w - 1);
            7:  return -w;
            8:  return -(w + 1);
            9:  return -63;
            default: return 5;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
            input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] d_op, input logic d_sz, input logic d_im,
            input logic [127:0] d_a, input logic [127:0] d_b, input logic [6:0] d_imm);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op       = d_op;
        size     = d_sz;
        use_imm  = d_im;
        a        = d_a;
        b        = d_b;
        imm      = d_imm;
        it.exp   = ref_model(d_op, d_sz, d_im, d_a, d_b, d_imm);
        it.tag   = tag_of(d_op, d_sz, d_im);
        last_exp = it.exp;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", result, '0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(result === it.exp, it.tag, result, it.exp);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        summary();
    end

    initial begin
        logic [127:0] pats [3];
        pats[0] = 128'h8000_0001_7FFF_FFFE_F0F0_1234_0F0F_ABCD;
        pats[1] = 128'hFFFF_FFFF_8421_8421_0000_8000_C3A5_5A3C;
        pats[2] = {$urandom, $urandom, $urandom, $urandom};

        rst = 1'b1; in_valid = 1'b0; op = '0; size = 1'b0; use_imm = 1'b0;
        a = '0; b = '0; imm = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset out_valid", {127'd0, out_valid}, '0);
        check(result === '0, "R1 reset result", result, '0);
        rst = 1'b0;

        for (int sz = 0; sz < 2; sz++) begin
            for (int o = 0; o < 8; o++) begin
                for (int fm = 0; fm < 2; fm++) begin
                    for (int j = 0; j < 11; j++) begin
                        for (int p = 0; p < 3; p++) begin
                            int w;
                            logic [127:0] bv;
                            w  = (sz == 0) ? 32 : 16;
                            bv = '0;
                            if (sz == 0) begin
                                for (int e = 0; e < 4; e++)
                                    bv[127-32*e -: 32] = 32'(cnt_pick(j + e, w));
                            end else begin
                                for (int e = 0; e < 8; e++)
                                    bv[127-16*e -: 16] = (16'(cnt_pick(j + e, w)) & 16'h00FF)
                                                         | 16'hA500;
                            end
                            drive(3'(o), sz[0], fm[0], pats[p], bv, 7'(cnt_pick(j, w)));
                        end
                    end
                end
            end
        end

        drive(3'd0, 1'b0, 1'b1, pats[0], '0, 7'd4);
        @(negedge clk);
        in_valid = 1'b0;
        a = ~a;
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0, "R1 idle out_valid", {127'd0, out_valid}, '0);
        check(result === last_exp, "R1 idle hold", result, last_exp);
        check(sb_q.size() == 0, "R1 scoreboard drained", 128'(sb_q.size()), '0);
        summary();
    end

endmodule